// File: doc/BRIEF.md
# Phase Accumulator Waveform Generator

This block produces a stream of signed 14-bit samples from a 32-bit phase accumulator. Each accepted sample moves the accumulator forward by a tuning word, so the output frequency is the tuning word times the sample rate divided by 2^32. A 16-bit phase offset is added to the top sixteen accumulator bits. The resulting phase is then mapped to one of three shapes: a square wave with a programmable 16-bit duty threshold, a triangle, or a ramp.

Samples leave through a valid/ready output. The sample rate is the rate at which the consumer accepts samples. With `smp_ready` tied high, the accumulator steps on every clock. A changed tuning word only changes the step size and never clears the phase, so retuning is phase-continuous. The enable, tuning word, offset, duty and shape select are plain control inputs and are sampled on every clock edge.

Back-pressure rules:
- While `smp_valid` is high and `smp_ready` is low, `smp_data` and the accumulator stay unchanged.
- Dropping `en` withdraws `smp_valid` on the next edge, even in the middle of a stall. This is the only case where a pending sample is abandoned.

Top module: `phase_wave_gen`

## Requirements
- R1: After reset, `smp_valid` is 0, `smp_data` is 0 and the accumulator is 0.
- R2: Each accepted step adds `tune_word` to the accumulator modulo 2^32. A step happens on an edge where `en` is 1 and either `smp_valid` is 0 or `smp_ready` is 1.
- R3: Changing `tune_word` never clears the accumulator. The sample after a retune continues from the phase that was reached.
- R4: The mapped phase P is (accumulator bits 31:16 + `phase_ofs`) modulo 65536.
- R5: With `wave_sel` = 0 (square), the sample is +8191 when P < `duty`, and −8192 otherwise.
- R6: With `wave_sel` = 1 (triangle), the sample is (F >> 1) − 8192. F is P when P < 32768, and 65535 − P otherwise.
- R7: With `wave_sel` = 2 (ramp), the sample is (P >> 2) − 8192.
- R8: With `wave_sel` = 3, the sample is 0 and it is still delivered with `smp_valid` high.
- R9: On an edge where `en` is 0, `smp_valid` and `smp_data` go to 0 and the accumulator holds. After re-enabling, the phase resumes from where it stopped.
- R10: While `smp_valid` is 1 and `smp_ready` is 0 with `en` high, `smp_data` stays the same, `smp_valid` stays 1 and the accumulator does not move.
- R11: A step registers the sample computed from the accumulator value before that step. That sample appears one cycle after the edge where the inputs were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| tune_word | input | 32 | Phase step per accepted sample |
| phase_ofs | input | 16 | Phase offset added to the top accumulator bits |
| duty | input | 16 | Square-wave high threshold |
| wave_sel | input | 2 | 0 square, 1 triangle, 2 ramp, 3 zero |
| smp_data | output | 14 | Signed sample |
| smp_valid | output | 1 | Sample present |
| smp_ready | input | 1 | Consumer accepts sample |

## Verification
Stall handling can fall in the same cycle as a retune or a disable. The bench changes `tune_word` and the shape while `smp_ready` is low, and drops `en` in the middle of a stall. The reference model then has to show three things:
- the held sample does not move;
- the new step size is used only from the next accepted sample on;
- the disable wins over the pending sample.

A behavioural model of the accumulator is compared against the outputs on every clock.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic [1:0] {
    WAVE_SQUARE = 2'd0,
    WAVE_TRI    = 2'd1,
    WAVE_RAMP   = 2'd2,
    WAVE_ZERO   = 2'd3
  } wave_e;
endpackage

// File: rtl/pwg_phase_acc.sv
module pwg_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [ACC_W-1:0] tune_word,
  output logic [ACC_W-1:0] acc_q
);
  // Wraps naturally modulo 2^ACC_W; never cleared except by reset.
  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= acc_q + tune_word;
  end
endmodule

// File: rtl/pwg_shaper.sv
module pwg_shaper
  import pwg_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int SMP_W = 14
) (
  input  logic [PH_W-1:0]         phase_in,
  input  logic [PH_W-1:0]         phase_ofs,
  input  logic [PH_W-1:0]         duty,
  input  logic [1:0]              wave_sel,
  output logic signed [SMP_W-1:0] sample
);
  localparam int RAMP_SH = PH_W - SMP_W;
  localparam int TRI_SH  = PH_W - 1 - SMP_W;
  localparam logic [SMP_W-1:0] SQ_HI = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] SQ_LO = {1'b1, {(SMP_W-1){1'b0}}};

  logic [PH_W-1:0]  ph;
  logic [PH_W-2:0]  fold;
  logic [SMP_W-1:0] ramp_u, tri_u, sq_v;

  assign ph   = phase_in + phase_ofs;
  assign fold = ph[PH_W-1] ? ~ph[PH_W-2:0] : ph[PH_W-2:0];

  generate
    if (RAMP_SH > 0) begin : g_ramp_shift
      assign ramp_u = SMP_W'(ph >> RAMP_SH);
    end else begin : g_ramp_direct
      assign ramp_u = SMP_W'(ph);
    end
    if (TRI_SH > 0) begin : g_tri_shift
      assign tri_u = SMP_W'(fold >> TRI_SH);
    end else begin : g_tri_direct
      assign tri_u = SMP_W'(fold);
    end
  endgenerate

  assign sq_v = (ph < duty) ? SQ_HI : SQ_LO;

  always_comb begin
    unique case (wave_e'(wave_sel))
      WAVE_SQUARE: sample = sq_v;
      WAVE_TRI:    sample = {~tri_u[SMP_W-1], tri_u[SMP_W-2:0]};
      WAVE_RAMP:   sample = {~ramp_u[SMP_W-1], ramp_u[SMP_W-2:0]};
      default:     sample = '0;
    endcase
  end
endmodule

// File: rtl/pwg_out_stage.sv
module pwg_out_stage #(
  parameter int SMP_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    ready,
  input  logic signed [SMP_W-1:0] sample_in,
  output logic signed [SMP_W-1:0] data_q,
  output logic                    valid_q,
  output logic                    advance
);
  assign advance = en && (!valid_q || ready);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (advance) begin
      valid_q <= 1'b1;
      data_q  <= sample_in;
    end
  end
endmodule

// File: rtl/phase_wave_gen.sv
module phase_wave_gen #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16,
  parameter int SMP_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ACC_W-1:0]        tune_word,
  input  logic [PH_W-1:0]         phase_ofs,
  input  logic [PH_W-1:0]         duty,
  input  logic [1:0]              wave_sel,
  output logic signed [SMP_W-1:0] smp_data,
  output logic                    smp_valid,
  input  logic                    smp_ready
);
  logic [ACC_W-1:0]        acc_q;
  logic                    step;
  logic signed [SMP_W-1:0] shaped;

  pwg_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(step),
    .tune_word(tune_word), .acc_q(acc_q)
  );

  pwg_shaper #(.PH_W(PH_W), .SMP_W(SMP_W)) u_shape (
    .phase_in(acc_q[ACC_W-1 -: PH_W]), .phase_ofs(phase_ofs),
    .duty(duty), .wave_sel(wave_sel), .sample(shaped)
  );

  pwg_out_stage #(.SMP_W(SMP_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .ready(smp_ready),
    .sample_in(shaped), .data_q(smp_data), .valid_q(smp_valid),
    .advance(step)
  );
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker #(
  parameter int ACC_W = 32,
  parameter int SMP_W = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic [ACC_W-1:0]        tune_word,
  input logic [1:0]              wave_sel,
  input logic signed [SMP_W-1:0] smp_data,
  input logic                    smp_valid,
  input logic                    smp_ready,
  input logic [ACC_W-1:0]        acc
);
  localparam logic [SMP_W-1:0] HI = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] LO = {1'b1, {(SMP_W-1){1'b0}}};

  logic acc_ok;
  assign acc_ok = en && (!smp_valid || smp_ready);

  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> (acc == $past(acc) + $past(tune_word)));

  assert_square_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && wave_sel == 2'd0) |=> (smp_data == HI || smp_data == LO));

  assert_zero_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && wave_sel == 2'd3) |=> (smp_valid && smp_data == '0));

  assert_idle_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!smp_valid && smp_data == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(acc)));
endmodule

bind phase_wave_gen pwg_checker #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_pwg_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tune_word(tune_word),
  .wave_sel(wave_sel), .smp_data(smp_data), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .acc(acc_q)
);

// File: tb/test_phase_wave_gen.sv
module test_phase_wave_gen;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               en;
  logic [31:0]        tune_word;
  logic [15:0]        phase_ofs, duty;
  logic [1:0]         wave_sel;
  logic               smp_ready;
  logic signed [13:0] smp_data;
  logic               smp_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_acc;
  bit          m_valid;
  int          m_data;

  always #4 clk = ~clk;

  phase_wave_gen i_phase_wave_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .tune_word(tune_word),
    .phase_ofs(phase_ofs), .duty(duty), .wave_sel(wave_sel),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready)
  );

  function automatic int ref_sample(logic [31:0] a, int ofs, int dt, int sel);
    int p, f;
    p = (int'(a[31:16]) + ofs) % 65536;
    case (sel)
      0: return (p < dt) ? 8191 : -8192;
      1: begin
        f = (p < 32768) ? p : 65535 - p;
        return (f >> 1) - 8192;
      end
      2: return (p >> 2) - 8192;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, bit v, int d);
    n_chk++;
    if (smp_valid !== v || int'(smp_data) !== d) begin
      n_fail++;
      $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
               req, smp_valid, smp_data, v, d);
    end
  endtask

  // Drive one cycle at a negedge, advance model, compare at next negedge.
  task automatic cyc(string req, bit e, logic [31:0] tw, int ofs, int dt,
                     int sel, bit rdy);
    en = e; tune_word = tw; phase_ofs = 16'(ofs); duty = 16'(dt);
    wave_sel = 2'(sel); smp_ready = rdy;
    if (!e) begin
      m_valid = 0; m_data = 0;
    end else if (!m_valid || rdy) begin
      m_data  = ref_sample(m_acc, ofs, dt, sel);
      m_valid = 1;
      m_acc   = m_acc + tw;
    end
    @(negedge clk);
    check(req, m_valid, m_data);
  endtask

  initial begin
    rst_n = 0; en = 0; tune_word = 0; phase_ofs = 0; duty = 0;
    wave_sel = 0; smp_ready = 1;
    m_acc = 0; m_valid = 0; m_data = 0;
    repeat (3) @(negedge clk);
    check("R1", 0, 0);
    rst_n = 1;
    // R11: first sample uses phase 0, one cycle latency
    cyc("R11", 1, 32'h0A3D70A3, 0, 0, 2, 1);
    if (int'(smp_data) !== -8192) begin
      n_fail++; $display("FAIL R11: data=%0d expected -8192", smp_data);
    end
    n_chk++;
    for (int i = 0; i < 40; i++) cyc("R7", 1, 32'h0A3D70A3, 0, 0, 2, 1);
    for (int i = 0; i < 40; i++) cyc("R6", 1, 32'h07000001, 0, 0, 1, 1);
    for (int i = 0; i < 80; i++) cyc("R5", 1, 32'h01000000, 0, 16'h4000, 0, 1);
    for (int i = 0; i < 10; i++) cyc("R5", 1, 32'h10000000, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) cyc("R5", 1, 32'h10000000, 0, 16'hFFFF, 0, 1);
    for (int i = 0; i < 20; i++) cyc("R4", 1, 32'h00100000, 16'h8000, 0, 2, 1);
    for (int i = 0; i < 20; i++) cyc("R4", 1, 32'h03300000, 16'hFFFF, 0, 1, 1);
    for (int i = 0; i < 20; i++) cyc("R3", 1, 32'h02000000, 0, 0, 1, 1);
    for (int i = 0; i < 20; i++) cyc("R3", 1, 32'h00555555, 0, 0, 1, 1);
    for (int i = 0; i < 20; i++) cyc("R2", 1, 32'hFFFFFFFF, 0, 0, 2, 1);
    for (int i = 0; i < 20; i++) cyc("R2", 1, 32'hF0000000, 0, 0, 2, 1);
    for (int i = 0; i < 5;  i++) cyc("R2", 1, 32'h0, 0, 0, 2, 1);
    for (int i = 0; i < 10; i++) cyc("R8", 1, 32'h12345678, 0, 0, 3, 1);
    for (int i = 0; i < 5;  i++) cyc("R9", 0, 32'h12345678, 0, 0, 2, 1);
    for (int i = 0; i < 10; i++) cyc("R9", 1, 32'h12345678, 0, 0, 2, 1);
    for (int i = 0; i < 30; i++)
      cyc("R10", 1, 32'h04000000, 0, 16'h8000, i % 3, (i % 3) != 0);
    // stall combined with retune and shape change
    for (int i = 0; i < 4; i++) cyc("R10", 1, 32'h01000000, 0, 0, 2, 1);
    for (int i = 0; i < 6; i++) cyc("R10", 1, 32'h09000000 + 32'(i), 0, 0, i % 3, 0);
    for (int i = 0; i < 6; i++) cyc("R3", 1, 32'h09000000, 0, 0, 2, 1);
    // disable during stall
    cyc("R10", 1, 32'h06000000, 0, 0, 1, 0);
    cyc("R10", 1, 32'h06000000, 0, 0, 1, 0);
    cyc("R9", 0, 32'h06000000, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) cyc("R9", 1, 32'h06000000, 0, 0, 1, 1);
    // reset mid-run
    rst_n = 0; en = 1; smp_ready = 1;
    @(negedge clk);
    check("R1", 0, 0);
    rst_n = 1; m_acc = 0; m_valid = 0; m_data = 0;
    for (int i = 0; i < 6; i++) cyc("R1", 1, 32'h20000000, 0, 0, 2, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule